// File: doc/BRIEF.md
# DDR DLL-Aware Command Timing Gate

This block sits in a DDR SDRAM controller between the command scheduler and the command bus. The scheduler raises requests for five command classes: read, non-read (any other access), extended mode register write, self-refresh entry and self-refresh exit. The gate grants at most one of them per cycle and drives the granted command onto a registered command output, with its bank-address and address bits.

The gate keeps two lockout counters, one for reads and one for non-read commands. It loads them whenever the memory's DLL is switched on. The non-read wait is short after a register write and longer after self-refresh exit. The read wait is the long DLL lock time in both cases. The gate also builds the extended mode register word from three configuration bits. It remembers whether the DLL was last programmed on or off, so reads stay blocked while the DLL is off.

Top module: `ddr_dll_cmd_gate`

## Requirements
- R1: After the synchronous active-high reset, `cmd_valid` is 0, `rd_ready` is 0, `nrd_ready` is 1 and `busy` is 0. Reads stay blocked until a register write enables the DLL.
- R2: A granted register write is issued with `cmd_ba` = 2'b01 (BA0 high, BA1 low). On `cmd_addr`, bit 0 = `cfg_dll_off` (0 = DLL on), bit 1 = `cfg_drive_weak` (0 = normal drive), bit 2 = `cfg_qfc_en`, and every higher bit is 0.
- R3: A register write is granted only in a cycle where `banks_idle` is 1. Otherwise it is held off until `banks_idle` is 1. Self-refresh entry has the same condition.
- R4: If a register write that enables the DLL is granted in cycle t, no read is granted before cycle t+RD_WAIT.
- R5: If a register write is granted in cycle t, no non-read command, register write or self-refresh entry is granted before cycle t+EMR_NR_WAIT.
- R6: If self-refresh exit is granted in cycle t, no non-read command is granted before cycle t+SRX_NR_WAIT, and no read is granted before cycle t+RD_WAIT. The read wait restarts at exit even if it had not run out.
- R7: From the cycle after a self-refresh entry grant until the exit grant, only `req_srx` can be granted. Outside self refresh, `req_srx` is never granted.
- R8: After a register write with `cfg_dll_off` = 1, no read is granted, even across a self-refresh cycle, until a later register write with `cfg_dll_off` = 0.
- R9: At most one grant is active per cycle. The priority is register write, then self-refresh entry, then non-read, then read.
- R10: A grant in cycle t makes `cmd_valid` 1 in cycle t+1, with `cmd_code` 1 = read, 2 = non-read, 3 = register write, 4 = self-refresh entry, 5 = self-refresh exit. Reads and non-reads carry `req_ba` and `req_addr`. Self-refresh commands carry zero bank and address. With no grant, `cmd_valid`, `cmd_code`, `cmd_ba` and `cmd_addr` are 0.
- R11: The lockout counters are 8 bits, count down to zero and stay there. `nrd_ready` is 1 when the non-read counter is zero outside self refresh. `rd_ready` is 1 when, in addition, the read counter is zero and the DLL is programmed on. `busy` is 1 while either counter is nonzero or the memory is in self refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_rd | input | 1 | Read request |
| req_nrd | input | 1 | Non-read command request |
| req_emr | input | 1 | Extended mode register write request |
| req_sre | input | 1 | Self-refresh entry request |
| req_srx | input | 1 | Self-refresh exit request |
| banks_idle | input | 1 | All banks idle |
| req_ba | input | 2 | Bank address for read and non-read requests |
| req_addr | input | ADDR_W | Address for read and non-read requests |
| cfg_dll_off | input | 1 | Register-write DLL control, 1 = off |
| cfg_drive_weak | input | 1 | Register-write drive strength, 1 = reduced |
| cfg_qfc_en | input | 1 | Register-write module isolation output enable |
| gnt_rd | output | 1 | Read granted |
| gnt_nrd | output | 1 | Non-read granted |
| gnt_emr | output | 1 | Register write granted |
| gnt_sre | output | 1 | Self-refresh entry granted |
| gnt_srx | output | 1 | Self-refresh exit granted |
| cmd_valid | output | 1 | Issued command valid |
| cmd_code | output | 3 | Issued command code |
| cmd_ba | output | 2 | Issued bank address |
| cmd_addr | output | ADDR_W | Issued address |
| rd_ready | output | 1 | A read could be granted now |
| nrd_ready | output | 1 | A non-read could be granted now |
| busy | output | 1 | Lockout running or in self refresh |

## Verification
The bench builds the gate with RD_WAIT = 24, EMR_NR_WAIT = 3 and SRX_NR_WAIT = 6 instead of the default 200/2/10. With these values the read lockout runs out many times within a short random run, so reads and non-reads that race the counters are covered often. The distinct short waits make a value swapped between the register-write and exit paths show up as a wrong gap. Directed runs measure the exact first-grant gap after each kind of DLL enable.

// File: rtl/ddr_dll_cmd_gate.sv
module ddr_dll_cmd_gate #(
  parameter int ADDR_W      = 13,
  parameter int CNT_W       = 8,
  parameter int RD_WAIT     = 200,
  parameter int EMR_NR_WAIT = 2,
  parameter int SRX_NR_WAIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_nrd,
  input  logic              req_emr,
  input  logic              req_sre,
  input  logic              req_srx,
  input  logic              banks_idle,
  input  logic [1:0]        req_ba,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_dll_off,
  input  logic              cfg_drive_weak,
  input  logic              cfg_qfc_en,
  output logic              gnt_rd,
  output logic              gnt_nrd,
  output logic              gnt_emr,
  output logic              gnt_sre,
  output logic              gnt_srx,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [1:0]        cmd_ba,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              rd_ready,
  output logic              nrd_ready,
  output logic              busy
);

  localparam logic [CNT_W-1:0] RD_LOAD  = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] EMR_LOAD = CNT_W'(EMR_NR_WAIT - 1);
  localparam logic [CNT_W-1:0] SRX_LOAD = CNT_W'(SRX_NR_WAIT - 1);
  localparam logic [2:0] C_RD = 3'd1, C_NRD = 3'd2, C_EMR = 3'd3,
                         C_SRE = 3'd4, C_SRX = 3'd5;

  logic [CNT_W-1:0]  rd_cnt, nrd_cnt, rd_dec, nrd_dec;
  logic              dll_on, in_sr;
  logic [ADDR_W-1:0] emr_word;

  assign rd_dec  = (rd_cnt  == '0) ? '0 : rd_cnt  - 1'b1;
  assign nrd_dec = (nrd_cnt == '0) ? '0 : nrd_cnt - 1'b1;

  assign nrd_ready = !in_sr && (nrd_cnt == '0);
  assign rd_ready  = !in_sr && dll_on && (rd_cnt == '0);
  assign busy      = in_sr || (rd_cnt != '0) || (nrd_cnt != '0);

  assign gnt_srx = in_sr && req_srx;
  assign gnt_emr = req_emr && nrd_ready && banks_idle;
  assign gnt_sre = req_sre && nrd_ready && banks_idle && !gnt_emr;
  assign gnt_nrd = req_nrd && nrd_ready && !gnt_emr && !gnt_sre;
  assign gnt_rd  = req_rd && rd_ready && !gnt_emr && !gnt_sre && !gnt_nrd;

  always_comb begin
    emr_word    = '0;
    emr_word[0] = cfg_dll_off;
    emr_word[1] = cfg_drive_weak;
    emr_word[2] = cfg_qfc_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt  <= '0;
      nrd_cnt <= '0;
      dll_on  <= 1'b0;
      in_sr   <= 1'b0;
    end else if (gnt_srx) begin
      in_sr   <= 1'b0;
      rd_cnt  <= RD_LOAD;
      nrd_cnt <= SRX_LOAD;
    end else if (gnt_emr) begin
      dll_on  <= !cfg_dll_off;
      nrd_cnt <= EMR_LOAD;
      rd_cnt  <= cfg_dll_off ? rd_dec : RD_LOAD;
    end else begin
      if (gnt_sre) in_sr <= 1'b1;
      rd_cnt  <= rd_dec;
      nrd_cnt <= nrd_dec;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_ba    <= '0;
      cmd_addr  <= '0;
    end else begin
      cmd_valid <= gnt_rd | gnt_nrd | gnt_emr | gnt_sre | gnt_srx;
      cmd_code  <= '0;
      cmd_ba    <= '0;
      cmd_addr  <= '0;
      if (gnt_srx) cmd_code <= C_SRX;
      else if (gnt_emr) begin
        cmd_code <= C_EMR;
        cmd_ba   <= 2'b01;
        cmd_addr <= emr_word;
      end else if (gnt_sre) cmd_code <= C_SRE;
      else if (gnt_nrd) begin
        cmd_code <= C_NRD;
        cmd_ba   <= req_ba;
        cmd_addr <= req_addr;
      end else if (gnt_rd) begin
        cmd_code <= C_RD;
        cmd_ba   <= req_ba;
        cmd_addr <= req_addr;
      end
    end
  end

endmodule

module ddr_dll_cmd_gate_chk #(
  parameter int RD_WAIT     = 200,
  parameter int EMR_NR_WAIT = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       gnt_rd,
  input logic       gnt_nrd,
  input logic       gnt_emr,
  input logic       gnt_sre,
  input logic       gnt_srx,
  input logic       banks_idle,
  input logic       cfg_dll_off,
  input logic       rd_ready,
  input logic       nrd_ready,
  input logic       cmd_valid,
  input logic [1:0] cmd_ba
);

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_rd, gnt_nrd, gnt_emr, gnt_sre, gnt_srx}));

  assert_emr_idle_R3: assert property (@(posedge clk) disable iff (rst)
    gnt_emr |-> banks_idle);

  assert_emr_bank_R2: assert property (@(posedge clk) disable iff (rst)
    gnt_emr |=> cmd_ba == 2'b01);

  assert_issue_next_R10: assert property (@(posedge clk) disable iff (rst)
    (gnt_rd | gnt_nrd | gnt_emr | gnt_sre | gnt_srx) |=> cmd_valid);

  assert_srx_lock_R6: assert property (@(posedge clk) disable iff (rst)
    gnt_srx |=> !rd_ready);

  assert_sr_hold_R7: assert property (@(posedge clk) disable iff (rst)
    gnt_sre |=> !(gnt_rd | gnt_nrd | gnt_emr | gnt_sre));

  generate
    if (RD_WAIT > 1) begin : g_rd
      assert_emr_rd_lock_R4: assert property (@(posedge clk) disable iff (rst)
        (gnt_emr && !cfg_dll_off) |=> !rd_ready);
    end
    if (EMR_NR_WAIT > 1) begin : g_nr
      assert_emr_nr_lock_R5: assert property (@(posedge clk) disable iff (rst)
        gnt_emr |=> !nrd_ready);
    end
  endgenerate

endmodule

bind ddr_dll_cmd_gate ddr_dll_cmd_gate_chk #(
  .RD_WAIT(RD_WAIT), .EMR_NR_WAIT(EMR_NR_WAIT)
) u_chk (
  .clk(clk), .rst(rst), .gnt_rd(gnt_rd), .gnt_nrd(gnt_nrd), .gnt_emr(gnt_emr),
  .gnt_sre(gnt_sre), .gnt_srx(gnt_srx), .banks_idle(banks_idle),
  .cfg_dll_off(cfg_dll_off), .rd_ready(rd_ready), .nrd_ready(nrd_ready),
  .cmd_valid(cmd_valid), .cmd_ba(cmd_ba)
);

// File: tb/tb_ddr_dll_cmd_gate.sv
module tb_ddr_dll_cmd_gate;
  localparam int AW = 13, RW = 24, EW = 3, SW = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, req_rd, req_nrd, req_emr, req_sre, req_srx, banks_idle;
  logic [1:0] req_ba;
  logic [AW-1:0] req_addr;
  logic cfg_dll_off, cfg_drive_weak, cfg_qfc_en;
  logic gnt_rd, gnt_nrd, gnt_emr, gnt_sre, gnt_srx, cmd_valid, rd_ready, nrd_ready, busy;
  logic [2:0] cmd_code;
  logic [1:0] cmd_ba;
  logic [AW-1:0] cmd_addr;

  ddr_dll_cmd_gate #(.ADDR_W(AW), .CNT_W(8), .RD_WAIT(RW), .EMR_NR_WAIT(EW),
                     .SRX_NR_WAIT(SW)) dut (.*);

  int total = 0, bad = 0;
  int m_rd, m_nrd;
  bit m_on, m_sr, m_cv;
  bit [2:0] m_code;
  bit [1:0] m_ba;
  bit [AW-1:0] m_addr;
  logic [4:0] dg;

  task automatic chk(string r, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic bit [4:0] exp_g();
    bit nr, rr, e, s, n, r, x;
    nr = !m_sr && m_nrd == 0;
    rr = !m_sr && m_on && m_rd == 0;
    x = m_sr && req_srx;
    e = req_emr && nr && banks_idle;
    s = req_sre && nr && banks_idle && !e;
    n = req_nrd && nr && !e && !s;
    r = req_rd && rr && !e && !s && !n;
    return {x, e, s, n, r};
  endfunction

  function automatic int dec(int v);
    return (v > 0) ? v - 1 : 0;
  endfunction

  task automatic check_state();
    chk("R10", "cmd_valid", cmd_valid, m_cv);
    chk("R10", "cmd_code", cmd_code, m_code);
    chk("R10", "cmd_ba", cmd_ba, m_ba);
    chk("R10", "cmd_addr", cmd_addr, m_addr);
    chk("R11", "nrd_ready", nrd_ready, !m_sr && m_nrd == 0);
    chk("R11", "rd_ready", rd_ready, !m_sr && m_on && m_rd == 0);
    chk("R11", "busy", busy, m_sr || m_rd != 0 || m_nrd != 0);
  endtask

  task automatic cycle();
    bit [4:0] g;
    #1;
    g = exp_g();
    dg = {gnt_srx, gnt_emr, gnt_sre, gnt_nrd, gnt_rd};
    chk("R9", "grants", dg, g);
    m_cv = |g; m_code = 0; m_ba = 0; m_addr = 0;
    if (g[4]) m_code = 5;
    else if (g[3]) begin
      m_code = 3; m_ba = 2'b01;
      m_addr = AW'({cfg_qfc_en, cfg_drive_weak, cfg_dll_off});
    end else if (g[2]) m_code = 4;
    else if (g[1]) begin m_code = 2; m_ba = req_ba; m_addr = req_addr; end
    else if (g[0]) begin m_code = 1; m_ba = req_ba; m_addr = req_addr; end
    if (g[4]) begin m_sr = 0; m_rd = RW - 1; m_nrd = SW - 1; end
    else if (g[3]) begin
      m_on = !cfg_dll_off; m_nrd = EW - 1;
      m_rd = cfg_dll_off ? dec(m_rd) : RW - 1;
    end else begin
      if (g[2]) m_sr = 1;
      m_rd = dec(m_rd); m_nrd = dec(m_nrd);
    end
    @(posedge clk);
    @(negedge clk);
    check_state();
  endtask

  task automatic idle_in();
    req_rd = 0; req_nrd = 0; req_emr = 0; req_sre = 0; req_srx = 0;
    banks_idle = 1; req_ba = 0; req_addr = 0;
    cfg_dll_off = 0; cfg_drive_weak = 0; cfg_qfc_en = 0;
  endtask

  task automatic settle();
    idle_in();
    for (int i = 0; i < RW + 2; i++) cycle();
  endtask

  task automatic measure(output int n_nrd, output int n_rd);
    n_nrd = -1; n_rd = -1;
    for (int n = 1; n <= 4 * RW && (req_nrd || req_rd); n++) begin
      cycle();
      if (dg[1] && n_nrd < 0) begin n_nrd = n; req_nrd = 0; end
      if (dg[0] && n_rd < 0) begin n_rd = n; req_rd = 0; end
    end
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, b;
    void'($urandom(32'h5eed_0042));
    idle_in();
    rst = 1;
    m_rd = 0; m_nrd = 0; m_on = 0; m_sr = 0; m_cv = 0; m_code = 0; m_ba = 0; m_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "cmd_valid", cmd_valid, 0);
    chk("R1", "rd_ready", rd_ready, 0);
    chk("R1", "nrd_ready", nrd_ready, 1);
    chk("R1", "busy", busy, 0);
    req_rd = 1; cycle();
    chk("R1", "read before enable", dg[0], 0);

    // R3: register write held while banks active
    idle_in(); req_emr = 1; banks_idle = 0;
    for (int i = 0; i < 8; i++) begin
      cycle(); chk("R3", "emr held", dg[3], 0);
    end
    // R2: register word
    banks_idle = 1; cfg_drive_weak = 1; cfg_qfc_en = 1;
    cycle(); chk("R3", "emr once idle", dg[3], 1);
    chk("R2", "emr ba", cmd_ba, 2'b01);
    chk("R2", "emr addr", cmd_addr, 32'h6);

    // R4, R5: gaps after enabling register write
    settle();
    req_emr = 1; cycle(); chk("R4", "emr grant", dg[3], 1);
    req_emr = 0; req_nrd = 1; req_rd = 1;
    measure(a, b);
    chk("R5", "non-read gap", a, EW);
    chk("R4", "read gap", b, RW);

    // R7, R6: self refresh entry, hold, exit gaps
    settle();
    req_sre = 1; cycle(); chk("R7", "sre grant", dg[2], 1);
    req_rd = 1; req_nrd = 1; req_emr = 1;
    for (int i = 0; i < 6; i++) begin
      cycle(); chk("R7", "only exit in self refresh", dg, 0);
    end
    idle_in(); req_srx = 1; cycle(); chk("R7", "srx grant", dg[4], 1);
    req_srx = 0; req_nrd = 1; req_rd = 1;
    measure(a, b);
    chk("R6", "non-read gap after exit", a, SW);
    chk("R6", "read gap after exit", b, RW);
    req_srx = 1; cycle(); chk("R7", "srx outside", dg[4], 0);

    // R8: DLL programmed off
    settle();
    cfg_dll_off = 1; req_emr = 1; cycle();
    idle_in(); req_rd = 1;
    for (int i = 0; i < 2 * RW; i++) begin
      cycle(); chk("R8", "read while off", dg[0], 0);
    end
    req_rd = 0; req_sre = 1; cycle(); req_sre = 0; req_srx = 1; cycle();
    req_srx = 0; req_rd = 1;
    for (int i = 0; i < 2 * RW; i++) begin
      cycle(); chk("R8", "read after exit while off", dg[0], 0);
    end
    req_rd = 0; req_emr = 1; cycle(); req_emr = 0; req_rd = 1;
    measure(a, b);
    chk("R8", "read after re-enable", b, RW);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      req_rd = ($urandom % 100) < 40;
      req_nrd = ($urandom % 100) < 30;
      req_emr = ($urandom % 100) < 4;
      req_sre = ($urandom % 100) < 3;
      req_srx = ($urandom % 100) < 15;
      banks_idle = ($urandom % 100) < 70;
      req_ba = 2'($urandom);
      req_addr = AW'($urandom);
      cfg_dll_off = ($urandom % 100) < 25;
      cfg_drive_weak = 1'($urandom);
      cfg_qfc_en = 1'($urandom);
      cycle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule